// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move packet data through one narrow data port instead of addressing local packet memory directly. Software first programs a 16-bit start address and a 16-bit byte count through an 8-bit register port, one byte at a time. After that, each host strobe on the data port moves a single byte or a single 16-bit little-endian word between the port and local memory. The transfer width is chosen by a configuration bit.

After every transfer the engine advances its address pointer by the transfer size and lowers the remaining count. When the pointer reaches the end of a programmable ring, it is pulled back to the ring's first page. When the count runs out, the engine raises a completion flag in its status register. The flag is also raised at once when a read or write command is issued while the count is already zero. Only two address windows map to real storage: a 32-byte identification window at the bottom of the space and a packet RAM window set by parameters. Accesses outside both windows return all ones on reads and are dropped on writes.

Register map (reg_addr): 0 command, 1 address low, 2 address high, 3 count low, 4 count high, 5 configuration, 6 ring first page, 7 ring end page, 8 status. Reads of the address and count registers return the live pointer and the live remaining count. All other register addresses read as zero.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset the address, count, configuration, ring pages and status registers all read 0x00.
- R2: Writing register 1 or 2 replaces only the low or high byte of the address pointer. Writing register 3 or 4 replaces only the low or high byte of the count. The other byte keeps its value.
- R3: With configuration bit 0 clear, each data port write stores wdata[7:0] at the pointer's byte address. The pointer then advances by 1 and the count drops by 1.
- R4: With configuration bit 0 set, each access moves a 16-bit word at the pointer with bit 0 forced to zero. The low byte sits at the even address. The pointer advances by 2 from its unforced value.
- R5: If the advanced pointer equals ring end page × 256, it is reloaded with ring first page × 256.
- R6: A transfer with count ≤ transfer size sets the count to 0 and sets status bit 6. Otherwise the count drops by the transfer size.
- R7: A data port write while the count is 0 is ignored. Memory is not written, and the pointer and status are unchanged.
- R8: Writing the command register with bit 0 (read) or bit 1 (write) set while the count is 0 sets status bit 6 in the next cycle. Command value 0, or a nonzero count, leaves the flag clear.
- R9: Only byte addresses 0..31 and PKT_LO..PKT_HI-1 are valid. An invalid read returns 0x00FF in byte mode and 0xFFFF in word mode. An invalid write stores nothing, but the pointer and count still update.
- R10: Writing status with bit 6 set clears the flag. Writing status with bit 6 clear leaves the flag as it is.
- R11: A data port read with count 0 still transfers. It returns data, advances the pointer and sets status bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| dp_wr | input | 1 | Data port write strobe |
| dp_rd | input | 1 | Data port read strobe |
| dp_wdata | input | 16 | Data port write data |
| dp_rdata | output | 16 | Data port read data, valid while dp_rd is high |
| mem_addr | output | AW-1 | Local memory word address |
| mem_we | output | 1 | Local memory write enable |
| mem_be | output | 2 | Byte lane enables, bit 0 = even byte |
| mem_wdata | output | 16 | Local memory write data |
| mem_rdata | input | 16 | Local memory read data, combinational |

## Verification
A wrong pointer shows up on the very next data port read as an unexpected value, or as all ones where real data was expected. It also shows in the address registers in the cycle after the strobe. A wrong count or flag is visible one cycle after the transfer, in the count registers and status bit 6. A missed wrap misplaces every later access in the ring. Misrouted byte lanes appear as swapped bytes when word-written data is read back in byte mode.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [3:0] RA_CMD      = 4'd0;
  localparam logic [3:0] RA_ADR_LO   = 4'd1;
  localparam logic [3:0] RA_ADR_HI   = 4'd2;
  localparam logic [3:0] RA_CNT_LO   = 4'd3;
  localparam logic [3:0] RA_CNT_HI   = 4'd4;
  localparam logic [3:0] RA_CFG      = 4'd5;
  localparam logic [3:0] RA_RING_BEG = 4'd6;
  localparam logic [3:0] RA_RING_END = 4'd7;
  localparam logic [3:0] RA_STAT     = 4'd8;

  localparam int CMD_RD_BIT    = 0;
  localparam int CMD_WR_BIT    = 1;
  localparam int CFG_WIDE_BIT  = 0;
  localparam int STAT_DONE_BIT = 6;

  typedef struct packed {
    logic adr_lo;
    logic adr_hi;
    logic cnt_lo;
    logic cnt_hi;
  } load_t;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = AW - 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  input  logic          cnt_zero,
  input  logic          done_set,
  input  logic [AW-1:0] addr_q,
  input  logic [CW-1:0] cnt_q,
  output logic [7:0]    reg_rdata,
  output logic          cfg_wide,
  output logic [PW-1:0] first_pg,
  output logic [PW-1:0] last_pg,
  output logic          done_flag,
  output load_t         loads
);
  logic [7:0]    cmd_q, cmd_d, cfg_q, cfg_d;
  logic [PW-1:0] first_d, last_d;
  logic          flag_d;
  logic          cmd_en, cfg_en, first_en, last_en;
  logic          cmd_zero;
  logic [15:0]   a_ext, c_ext;

  always_comb begin
    cmd_d    = reg_wdata;
    cfg_d    = reg_wdata;
    first_d  = reg_wdata[PW-1:0];
    last_d   = reg_wdata[PW-1:0];
    cmd_en   = reg_wr && (reg_addr == RA_CMD);
    cfg_en   = reg_wr && (reg_addr == RA_CFG);
    first_en = reg_wr && (reg_addr == RA_RING_BEG);
    last_en  = reg_wr && (reg_addr == RA_RING_END);
    loads.adr_lo = reg_wr && (reg_addr == RA_ADR_LO);
    loads.adr_hi = reg_wr && (reg_addr == RA_ADR_HI);
    loads.cnt_lo = reg_wr && (reg_addr == RA_CNT_LO);
    loads.cnt_hi = reg_wr && (reg_addr == RA_CNT_HI);
    cmd_zero = cmd_en && cnt_zero &&
               (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);
    flag_d = done_flag;
    if (reg_wr && (reg_addr == RA_STAT) && reg_wdata[STAT_DONE_BIT])
      flag_d = 1'b0;
    if (done_set || cmd_zero)
      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      cfg_q     <= '0;
      first_pg  <= '0;
      last_pg   <= '0;
      done_flag <= 1'b0;
    end else begin
      if (cmd_en)   cmd_q    <= cmd_d;
      if (cfg_en)   cfg_q    <= cfg_d;
      if (first_en) first_pg <= first_d;
      if (last_en)  last_pg  <= last_d;
      done_flag <= flag_d;
    end
  end

  assign cfg_wide = cfg_q[CFG_WIDE_BIT];
  assign a_ext    = 16'(addr_q);
  assign c_ext    = 16'(cnt_q);

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      RA_CMD:      reg_rdata = cmd_q;
      RA_ADR_LO:   reg_rdata = a_ext[7:0];
      RA_ADR_HI:   reg_rdata = a_ext[15:8];
      RA_CNT_LO:   reg_rdata = c_ext[7:0];
      RA_CNT_HI:   reg_rdata = c_ext[15:8];
      RA_CFG:      reg_rdata = cfg_q;
      RA_RING_BEG: reg_rdata = 8'(first_pg);
      RA_RING_END: reg_rdata = 8'(last_pg);
      RA_STAT:     reg_rdata[STAT_DONE_BIT] = done_flag;
      default:     reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rdma_xfer.sv
module rdma_xfer
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = AW - 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          wide,
  input  logic [PW-1:0] first_pg,
  input  logic [PW-1:0] last_pg,
  input  load_t         loads,
  input  logic [7:0]    wdata,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          done_set
);
  localparam int CHW = CW - 8;

  logic [AW-1:0] addr_d, sum, step_a, ring_end, ring_beg;
  logic [CW-1:0] cnt_d, step_c;
  logic          addr_en, cnt_en;

  assign ring_end = {last_pg, 8'h00};
  assign ring_beg = {first_pg, 8'h00};

  always_comb begin
    step_a   = wide ? AW'(2) : AW'(1);
    step_c   = wide ? CW'(2) : CW'(1);
    sum      = addr_q + step_a;
    addr_d   = addr_q;
    cnt_d    = cnt_q;
    done_set = 1'b0;
    if (go) begin
      addr_d = (sum == ring_end) ? ring_beg : sum;
      if (cnt_q <= step_c) begin
        cnt_d    = '0;
        done_set = 1'b1;
      end else begin
        cnt_d = cnt_q - step_c;
      end
    end else begin
      if (loads.adr_lo) addr_d[7:0]    = wdata;
      if (loads.adr_hi) addr_d[AW-1:8] = wdata[PW-1:0];
      if (loads.cnt_lo) cnt_d[7:0]     = wdata;
      if (loads.cnt_hi) cnt_d[CW-1:8]  = wdata[CHW-1:0];
    end
    addr_en = go || loads.adr_lo || loads.adr_hi;
    cnt_en  = go || loads.cnt_lo || loads.cnt_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/rdma_lane.sv
module rdma_lane #(
  parameter int AW       = 16,
  parameter int PROM_TOP = 32,
  parameter int PKT_LO   = 16'h0400,
  parameter int PKT_HI   = 16'h0800
) (
  input  logic [AW-1:0] addr_q,
  input  logic          wide,
  input  logic          do_write,
  input  logic [15:0]   dp_wdata,
  input  logic [15:0]   mem_rdata,
  output logic [AW-2:0] mem_addr,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  output logic [15:0]   dp_rdata
);
  localparam logic [AW-1:0] PROM_LIM = AW'(PROM_TOP);
  localparam logic [AW-1:0] PKT_BEG  = AW'(PKT_LO);
  localparam logic [AW-1:0] PKT_END  = AW'(PKT_HI);

  logic [AW-1:0] acc;
  logic          valid;
  logic [7:0]    rd_byte;

  always_comb begin
    acc       = wide ? {addr_q[AW-1:1], 1'b0} : addr_q;
    valid     = (acc < PROM_LIM) || ((acc >= PKT_BEG) && (acc < PKT_END));
    mem_addr  = addr_q[AW-1:1];
    mem_we    = do_write && valid;
    mem_be    = wide ? 2'b11 : (addr_q[0] ? 2'b10 : 2'b01);
    mem_wdata = wide ? dp_wdata : {2{dp_wdata[7:0]}};
    rd_byte   = addr_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];
    if (!valid)
      dp_rdata = wide ? 16'hFFFF : 16'h00FF;
    else
      dp_rdata = wide ? mem_rdata : {8'h00, rd_byte};
  end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter int PROM_TOP = 32,
  parameter int PKT_LO   = 16'h0400,
  parameter int PKT_HI   = 16'h0800
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic          dp_wr,
  input  logic          dp_rd,
  input  logic [15:0]   dp_wdata,
  output logic [15:0]   dp_rdata,
  output logic [AW-2:0] mem_addr,
  output logic          mem_we,
  output logic [1:0]    mem_be,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam int PW = AW - 8;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [PW-1:0] first_pg, last_pg;
  logic          cfg_wide, done_flag, done_set, cnt_zero;
  logic          wr_commit, xfer_go;
  load_t         loads;

  assign cnt_zero  = (cnt_q == '0);
  assign wr_commit = dp_wr && !dp_rd && !cnt_zero;
  assign xfer_go   = dp_rd || wr_commit;

  rdma_regs #(.AW(AW), .CW(CW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cnt_zero(cnt_zero), .done_set(done_set),
    .addr_q(addr_q), .cnt_q(cnt_q), .reg_rdata(reg_rdata),
    .cfg_wide(cfg_wide), .first_pg(first_pg), .last_pg(last_pg),
    .done_flag(done_flag), .loads(loads)
  );

  rdma_xfer #(.AW(AW), .CW(CW), .PW(PW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .go(xfer_go), .wide(cfg_wide),
    .first_pg(first_pg), .last_pg(last_pg), .loads(loads),
    .wdata(reg_wdata), .addr_q(addr_q), .cnt_q(cnt_q), .done_set(done_set)
  );

  rdma_lane #(.AW(AW), .PROM_TOP(PROM_TOP), .PKT_LO(PKT_LO), .PKT_HI(PKT_HI)) u_lane (
    .addr_q(addr_q), .wide(cfg_wide), .do_write(wr_commit),
    .dp_wdata(dp_wdata), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .dp_rdata(dp_rdata)
  );
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk #(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter int PROM_TOP = 32,
  parameter int PKT_LO   = 16'h0400,
  parameter int PKT_HI   = 16'h0800,
  parameter int PW       = AW - 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic          dp_wr,
  input logic          dp_rd,
  input logic [AW-2:0] mem_addr,
  input logic          mem_we,
  input logic [1:0]    mem_be,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] cnt_q,
  input logic [PW-1:0] first_pg,
  input logic [PW-1:0] last_pg,
  input logic          cfg_wide,
  input logic          done_flag
);
  logic [CW-1:0] step;
  logic          moving;
  logic [AW-1:0] byte_a;
  logic          byte_ok;

  assign step    = cfg_wide ? CW'(2) : CW'(1);
  assign moving  = dp_rd || (dp_wr && (cnt_q != '0));
  assign byte_a  = {mem_addr, (mem_be == 2'b10)};
  assign byte_ok = (byte_a < AW'(PROM_TOP)) ||
                   ((byte_a >= AW'(PKT_LO)) && (byte_a < AW'(PKT_HI)));

  p_cnt_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    moving && (cnt_q > step) |=> cnt_q == $past(cnt_q) - $past(step));

  p_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    moving && (cnt_q <= step) |=> (cnt_q == '0) && done_flag);

  p_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dp_wr && !dp_rd && (cnt_q == '0) |-> !mem_we);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dp_wr && !dp_rd && (cnt_q == '0) && !reg_wr |=> $stable(addr_q));

  p_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> byte_ok);

  p_cmd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == 4'd0) && (reg_wdata[1:0] != 2'b00) && (cnt_q == '0)
    |=> done_flag);

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    moving && !reg_wr && (first_pg != last_pg)
    |=> addr_q != {$past(last_pg), 8'h00});
endmodule

bind rdma_port_engine rdma_port_engine_chk #(
  .AW(AW), .CW(CW), .PROM_TOP(PROM_TOP), .PKT_LO(PKT_LO), .PKT_HI(PKT_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .dp_wr(dp_wr), .dp_rd(dp_rd), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_be(mem_be), .addr_q(addr_q), .cnt_q(cnt_q),
  .first_pg(first_pg), .last_pg(last_pg), .cfg_wide(cfg_wide),
  .done_flag(done_flag)
);

// File: tb/rdma_port_engine_test.sv
module rdma_port_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        dp_wr = 1'b0;
  logic        dp_rd = 1'b0;
  logic [15:0] dp_wdata = '0;
  logic [15:0] dp_rdata;
  logic [14:0] mem_addr;
  logic        mem_we;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;

  logic [15:0] bmem [0:1023];
  int nchk = 0;
  int nerr = 0;
  logic [15:0] expq[$];
  string       reqq[$];
  event        samp;

  always #4 clk = ~clk;

  rdma_port_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_wr(dp_wr),
    .dp_rd(dp_rd), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  assign mem_rdata = bmem[mem_addr[9:0]];
  always @(posedge clk) begin
    if (mem_we) begin
      if (mem_be[0]) bmem[mem_addr[9:0]][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) bmem[mem_addr[9:0]][15:8] <= mem_wdata[15:8];
    end
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // scoreboard monitor for data port reads
  always @(samp) begin
    logic [15:0] e;
    string r;
    e = expq.pop_front();
    r = reqq.pop_front();
    check(r, dp_rdata, e);
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
    reg_addr = a;
    #1;
    check(req, {8'h00, reg_rdata}, {8'h00, exp});
  endtask

  task automatic setup(logic [15:0] a, logic [15:0] c);
    wr(4'd1, a[7:0]); wr(4'd2, a[15:8]);
    wr(4'd3, c[7:0]); wr(4'd4, c[15:8]);
  endtask

  task automatic dp_write(logic [15:0] d);
    @(negedge clk);
    dp_wr = 1'b1; dp_wdata = d;
    @(negedge clk);
    dp_wr = 1'b0;
  endtask

  task automatic dp_read(string req, logic [15:0] exp);
    expq.push_back(exp);
    reqq.push_back(req);
    @(negedge clk);
    dp_rd = 1'b1;
    #2;
    -> samp;
    @(negedge clk);
    dp_rd = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1", 4'd1, 8'h00); rd_chk("R1", 4'd2, 8'h00);
    rd_chk("R1", 4'd3, 8'h00); rd_chk("R1", 4'd4, 8'h00);
    rd_chk("R1", 4'd5, 8'h00); rd_chk("R1", 4'd7, 8'h00);
    rd_chk("R1", 4'd8, 8'h00);
    // R2 byte-wise loads
    wr(4'd1, 8'h34); rd_chk("R2", 4'd1, 8'h34); rd_chk("R2", 4'd2, 8'h00);
    wr(4'd2, 8'h05); rd_chk("R2", 4'd1, 8'h34);
    wr(4'd1, 8'h10); rd_chk("R2", 4'd2, 8'h05); rd_chk("R2", 4'd1, 8'h10);
    wr(4'd4, 8'h12); wr(4'd3, 8'h9A); rd_chk("R2", 4'd4, 8'h12);
    // ring pages
    wr(4'd6, 8'h04); wr(4'd7, 8'h08);
    // R3 byte writes, R6 completion, R7 ignore
    setup(16'h0400, 16'd3);
    dp_write(16'h00AA); dp_write(16'h00BB);
    rd_chk("R3", 4'd1, 8'h02); rd_chk("R6", 4'd3, 8'h01);
    rd_chk("R6", 4'd8, 8'h00);
    dp_write(16'h00CC);
    rd_chk("R6", 4'd3, 8'h00); rd_chk("R6", 4'd8, 8'h40);
    dp_write(16'h00DD);
    rd_chk("R7", 4'd1, 8'h03); rd_chk("R7", 4'd2, 8'h04);
    // R10 clear rules
    wr(4'd8, 8'h00); rd_chk("R10", 4'd8, 8'h40);
    wr(4'd8, 8'h40); rd_chk("R10", 4'd8, 8'h00);
    // R3/R7 read back
    setup(16'h0400, 16'd4);
    dp_read("R3", 16'h00AA); dp_read("R3", 16'h00BB);
    dp_read("R3", 16'h00CC); dp_read("R7", 16'h0000);
    rd_chk("R6", 4'd8, 8'h40);
    wr(4'd8, 8'h40);
    // R11 read with zero count
    dp_read("R11", 16'h0000);
    rd_chk("R11", 4'd1, 8'h05); rd_chk("R11", 4'd8, 8'h40);
    wr(4'd8, 8'h40);
    // R4 word mode
    wr(4'd5, 8'h01);
    setup(16'h0410, 16'd4);
    dp_write(16'h1234); dp_write(16'h5678);
    rd_chk("R4", 4'd1, 8'h14);
    wr(4'd5, 8'h00);
    setup(16'h0410, 16'd4);
    dp_read("R4", 16'h0034); dp_read("R4", 16'h0012);
    dp_read("R4", 16'h0078); dp_read("R4", 16'h0056);
    wr(4'd5, 8'h01);
    setup(16'h0411, 16'd2);
    dp_read("R4", 16'h1234);
    rd_chk("R4", 4'd1, 8'h13);
    wr(4'd8, 8'h40);
    // R5 ring wrap
    wr(4'd5, 8'h00);
    setup(16'h07FF, 16'd2);
    dp_write(16'h00EE);
    rd_chk("R5", 4'd1, 8'h00); rd_chk("R5", 4'd2, 8'h04);
    setup(16'h07FF, 16'd1);
    dp_read("R5", 16'h00EE);
    rd_chk("R5", 4'd2, 8'h04);
    wr(4'd5, 8'h01);
    setup(16'h07FE, 16'd2);
    dp_read("R5", 16'hEE00);
    rd_chk("R5", 4'd1, 8'h00); rd_chk("R5", 4'd2, 8'h04);
    // R9 windows
    setup(16'h0900, 16'd2);
    dp_read("R9", 16'hFFFF);
    wr(4'd5, 8'h00);
    setup(16'h0020, 16'd1);
    dp_read("R9", 16'h00FF);
    setup(16'h0005, 16'd1);
    dp_write(16'h005A);
    setup(16'h0005, 16'd1);
    dp_read("R9", 16'h005A);
    wr(4'd5, 8'h01);
    setup(16'h0C10, 16'd2);
    dp_write(16'hABCD);
    rd_chk("R9", 4'd1, 8'h12); rd_chk("R9", 4'd2, 8'h0C);
    setup(16'h0410, 16'd2);
    dp_read("R9", 16'h1234);
    // R8 command with zero count
    wr(4'd8, 8'h40); rd_chk("R8", 4'd8, 8'h00);
    wr(4'd0, 8'h01); rd_chk("R8", 4'd8, 8'h40); rd_chk("R8", 4'd0, 8'h01);
    wr(4'd8, 8'h40);
    wr(4'd0, 8'h02); rd_chk("R8", 4'd8, 8'h40);
    wr(4'd8, 8'h40);
    wr(4'd0, 8'h00); rd_chk("R8", 4'd8, 8'h00);
    setup(16'h0420, 16'd5);
    wr(4'd0, 8'h01); rd_chk("R8", 4'd8, 8'h00);
    // R6 word count partial
    setup(16'h0420, 16'd3);
    dp_write(16'h1111);
    rd_chk("R6", 4'd3, 8'h01); rd_chk("R6", 4'd8, 8'h00);
    dp_write(16'h2222);
    rd_chk("R6", 4'd3, 8'h00); rd_chk("R6", 4'd8, 8'h40);
    @(negedge clk);
    if (expq.size() != 0) begin
      nerr++;
      $display("FAIL scoreboard: got %0d pending expected 0", expq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule